// File: doc/BRIEF.md
# Transaction Checkpoint and Nesting Tracker

This block keeps the recovery state for one hardware thread running speculative transactions. When the outermost transaction opens, it copies a parallel snapshot of a small register set and the program counter into private storage, marks that copy valid and issues a fresh transaction identifier. Inner transactions only deepen a nesting count. When the outermost transaction commits, the copy is released. When any level aborts, or when a begin would exceed the nesting limit, the saved copy is driven onto a restore bus with a one-cycle restore strobe. A matching discard pulse tells the cache side to drop its speculative lines.

The core drives three single-cycle strobes: begin, commit and abort. When several arrive in the same cycle, only the highest-ranked one acts. Abort ranks above commit, and commit ranks above begin. The restore bus holds the values of the most recent restore until the next one. All results are registered and appear one clock after the edge that samples the strobe.

Top module: `txn_ckpt_tracker`

## Requirements
- R1: After reset, depth is 0, the identifier is 0, the checkpoint is not valid, and the restore strobe, discard, commit-complete and overflow outputs are all 0.
- R2: A begin at depth 0 stores the snapshot bus and the PC, sets valid, sets depth to 1 and advances the identifier by one (modulo 2^ID_W). All of this is visible one cycle later.
- R3: A begin at a depth between 1 and MAX_DEPTH-1 increments depth by one and leaves the stored checkpoint, the valid flag and the identifier unchanged.
- R4: A commit at depth greater than 1 decrements depth. A commit at depth 1 sets depth to 0, clears valid and pulses commit-complete for exactly one cycle.
- R5: An abort at any nonzero depth produces a one-cycle restore strobe on the next cycle. In that cycle the restore bus carries the checkpoint taken at the outermost begin, depth is 0 and valid is clear.
- R6: The cache discard output pulses in exactly the cycles in which the restore strobe is high.
- R7: A begin at depth MAX_DEPTH does not increment depth. It pulses the overflow flag together with a restore, handled exactly like an abort.
- R8: A commit or an abort at depth 0 is ignored. No output pulses, and depth, identifier, valid and the restore bus keep their values.
- R9: In a cycle with several strobes asserted, only the highest-ranked one is considered: abort first, then commit, then begin. If that strobe is ignored under R8, nothing happens in that cycle.
- R10: Register k of the snapshot and restore buses occupies bits [k*REG_W +: REG_W]. The restore bus and the restore PC hold their last restored values between restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| beginStb | input | 1 | Transaction begin strobe |
| commitStb | input | 1 | Transaction commit strobe |
| abortStb | input | 1 | Transaction abort strobe |
| snapRegs | input | NUM_REGS*REG_W | Parallel register snapshot |
| snapPc | input | PC_W | PC of the instruction before the begin |
| restoreRegs | output | NUM_REGS*REG_W | Restored register values |
| restorePc | output | PC_W | Restored program counter |
| restoreStb | output | 1 | One-cycle pulse: restore bus is to be applied |
| cacheDiscard | output | 1 | One-cycle pulse: drop speculative cache state |
| commitDone | output | 1 | One-cycle pulse: outermost commit completed |
| overflowFail | output | 1 | One-cycle pulse: nesting limit exceeded |
| depth | output | $clog2(MAX_DEPTH+1) | Current nesting depth |
| txnId | output | ID_W | Identifier of the current or last outermost transaction |
| ckptValid | output | 1 | Checkpoint holds live data |

## Verification
Every result of this block lands exactly one clock after the rising edge that samples a strobe. This covers depth, identifier, valid, the restore bus and all four pulses. The bench applies a strobe set before a rising edge and advances its behavioural model at that edge. It compares all outputs at the following falling edge, so each pulse is sampled in its single high cycle and again low one cycle later. Directed sequences cover nesting up to the limit, overflow, identifier wrap and mixed strobes. A long stream of random strobes follows.

// File: rtl/txn_ckpt_pkg.sv
package txn_ckpt_pkg;
  // Strobes the control side sends to the checkpoint datapath.
  typedef struct packed {
    logic capture;   // take a fresh snapshot (outermost begin)
    logic restore;   // move the snapshot onto the restore bus
  } ckptCtl_t;
endpackage

// File: rtl/txn_ckpt_ctrl.sv
module txn_ckpt_ctrl
  import txn_ckpt_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  parameter int ID_W      = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               beginStb,
  input  logic               commitStb,
  input  logic               abortStb,
  output ckptCtl_t           ctl,
  output logic [DEPTH_W-1:0] depth,
  output logic [ID_W-1:0]    txnId,
  output logic               ckptValid,
  output logic               restoreStb,
  output logic               cacheDiscard,
  output logic               commitDone,
  output logic               overflowFail
);
  localparam logic [DEPTH_W-1:0] DepthMax = DEPTH_W'(MAX_DEPTH);
  localparam logic [DEPTH_W-1:0] DepthOne = DEPTH_W'(1);

  logic inTxn, atMax;
  logic doAbort, doCommit, doBegin;
  logic outerBegin, innerBegin, overflowEv, restoreEv, lastCommit;

  always_comb begin
    inTxn      = (depth != '0);
    atMax      = (depth == DepthMax);
    // ranking: abort > commit > begin; lower strobes masked by higher ones
    doAbort    = abortStb && inTxn;
    doCommit   = commitStb && !abortStb && inTxn;
    doBegin    = beginStb && !abortStb && !commitStb;
    outerBegin = doBegin && !inTxn;
    innerBegin = doBegin && inTxn && !atMax;
    overflowEv = doBegin && atMax;
    restoreEv  = doAbort || overflowEv;
    lastCommit = doCommit && (depth == DepthOne);
    ctl.capture = outerBegin;
    ctl.restore = restoreEv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth        <= '0;
      txnId        <= '0;
      ckptValid    <= 1'b0;
      restoreStb   <= 1'b0;
      cacheDiscard <= 1'b0;
      commitDone   <= 1'b0;
      overflowFail <= 1'b0;
    end else begin
      restoreStb   <= restoreEv;
      cacheDiscard <= restoreEv;
      commitDone   <= lastCommit;
      overflowFail <= overflowEv;
      if (restoreEv) begin
        depth     <= '0;
        ckptValid <= 1'b0;
      end else if (outerBegin) begin
        depth     <= DepthOne;
        ckptValid <= 1'b1;
        txnId     <= txnId + 1'b1;
      end else if (innerBegin) begin
        depth <= depth + 1'b1;
      end else if (doCommit) begin
        depth <= depth - 1'b1;
        if (lastCommit) ckptValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txn_ckpt_data.sv
module txn_ckpt_data
  import txn_ckpt_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int PC_W     = 16,
  parameter int BUS_W    = NUM_REGS * REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ckptCtl_t         ctl,
  input  logic [BUS_W-1:0] snapRegs,
  input  logic [PC_W-1:0]  snapPc,
  output logic [BUS_W-1:0] restoreRegs,
  output logic [PC_W-1:0]  restorePc
);
  logic [PC_W-1:0] savedPc;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [REG_W-1:0] savedReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedReg                     <= '0;
        restoreRegs[k*REG_W +: REG_W] <= '0;
      end else begin
        if (ctl.capture) savedReg <= snapRegs[k*REG_W +: REG_W];
        if (ctl.restore) restoreRegs[k*REG_W +: REG_W] <= savedReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPc   <= '0;
      restorePc <= '0;
    end else begin
      if (ctl.capture) savedPc   <= snapPc;
      if (ctl.restore) restorePc <= savedPc;
    end
  end
endmodule

// File: rtl/txn_ckpt_tracker.sv
module txn_ckpt_tracker
  import txn_ckpt_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int REG_W     = 16,
  parameter int PC_W      = 16,
  parameter int MAX_DEPTH = 4,
  parameter int ID_W      = 8,
  localparam int BUS_W    = NUM_REGS * REG_W,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               beginStb,
  input  logic               commitStb,
  input  logic               abortStb,
  input  logic [BUS_W-1:0]   snapRegs,
  input  logic [PC_W-1:0]    snapPc,
  output logic [BUS_W-1:0]   restoreRegs,
  output logic [PC_W-1:0]    restorePc,
  output logic               restoreStb,
  output logic               cacheDiscard,
  output logic               commitDone,
  output logic               overflowFail,
  output logic [DEPTH_W-1:0] depth,
  output logic [ID_W-1:0]    txnId,
  output logic               ckptValid
);
  ckptCtl_t ctl;

  txn_ckpt_ctrl #(.MAX_DEPTH(MAX_DEPTH), .ID_W(ID_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .beginStb(beginStb), .commitStb(commitStb),
    .abortStb(abortStb), .ctl(ctl), .depth(depth), .txnId(txnId),
    .ckptValid(ckptValid), .restoreStb(restoreStb), .cacheDiscard(cacheDiscard),
    .commitDone(commitDone), .overflowFail(overflowFail)
  );

  txn_ckpt_data #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .PC_W(PC_W), .BUS_W(BUS_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .snapRegs(snapRegs), .snapPc(snapPc),
    .restoreRegs(restoreRegs), .restorePc(restorePc)
  );
endmodule

// File: rtl/txn_ckpt_chk.sv
module txn_ckpt_chk #(
  parameter int MAX_DEPTH = 4,
  parameter int ID_W      = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               beginStb,
  input logic               commitStb,
  input logic               abortStb,
  input logic [DEPTH_W-1:0] depth,
  input logic [ID_W-1:0]    txnId,
  input logic               ckptValid,
  input logic               restoreStb,
  input logic               cacheDiscard,
  input logic               commitDone,
  input logic               overflowFail
);
  // R2
  outer_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beginStb && !commitStb && !abortStb && depth == '0)
    |=> (depth == DEPTH_W'(1) && ckptValid && txnId == ID_W'($past(txnId) + 1'b1)));

  // R3
  inner_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beginStb && !commitStb && !abortStb && depth != '0 && depth < DEPTH_W'(MAX_DEPTH))
    |=> (depth == DEPTH_W'($past(depth) + 1'b1) && $stable(txnId) && ckptValid));

  // R4
  last_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && !abortStb && depth == DEPTH_W'(1))
    |=> (commitDone && depth == '0 && !ckptValid));

  // R5
  abort_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortStb && depth != '0) |=> (restoreStb && depth == '0 && !ckptValid));

  // R6
  discard_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreStb == cacheDiscard);

  // R7
  overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFail |-> (restoreStb && depth == '0));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(MAX_DEPTH));

  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((commitStb || abortStb) && depth == '0)
    |=> ($stable(depth) && $stable(txnId) && !restoreStb && !commitDone));
endmodule

bind txn_ckpt_tracker txn_ckpt_chk #(.MAX_DEPTH(MAX_DEPTH), .ID_W(ID_W), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .beginStb(beginStb), .commitStb(commitStb), .abortStb(abortStb),
  .depth(depth), .txnId(txnId), .ckptValid(ckptValid), .restoreStb(restoreStb),
  .cacheDiscard(cacheDiscard), .commitDone(commitDone), .overflowFail(overflowFail)
);

// File: tb/tb_txn_ckpt_tracker.sv
module tb_txn_ckpt_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int RW = 16;
  localparam int PW = 16;
  localparam int MAXD = 4;
  localparam int IW = 8;
  localparam int BW = NREG * RW;
  localparam int DW = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic beginStb = 1'b0, commitStb = 1'b0, abortStb = 1'b0;
  logic [BW-1:0] snapRegs = '0;
  logic [PW-1:0] snapPc = '0;
  logic [BW-1:0] restoreRegs;
  logic [PW-1:0] restorePc;
  logic restoreStb, cacheDiscard, commitDone, overflowFail, ckptValid;
  logic [DW-1:0] depth;
  logic [IW-1:0] txnId;

  int nChecks = 0;
  int nFails = 0;

  // behavioural reference state
  int mDepth = 0, mId = 0, mValid = 0, mPc = 0, mRstPc = 0;
  int mReg[NREG];
  int mRstReg[NREG];
  int mRst = 0, mOvf = 0, mDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_ckpt_tracker #(.NUM_REGS(NREG), .REG_W(RW), .PC_W(PW), .MAX_DEPTH(MAXD), .ID_W(IW)) dut (
    .clk(clk), .rstN(rstN), .beginStb(beginStb), .commitStb(commitStb), .abortStb(abortStb),
    .snapRegs(snapRegs), .snapPc(snapPc), .restoreRegs(restoreRegs), .restorePc(restorePc),
    .restoreStb(restoreStb), .cacheDiscard(cacheDiscard), .commitDone(commitDone),
    .overflowFail(overflowFail), .depth(depth), .txnId(txnId), .ckptValid(ckptValid)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic compare(input string tag);
    logic [BW-1:0] expRegs;
    for (int k = 0; k < NREG; k++) expRegs[k*RW +: RW] = RW'(mRstReg[k]);
    check(tag, "depth", longint'(depth), longint'(mDepth));
    check(tag, "txnId", longint'(txnId), longint'(mId));
    check(tag, "ckptValid", longint'(ckptValid), longint'(mValid));
    check(tag, "restoreStb", longint'(restoreStb), longint'(mRst));
    // R6: discard mirrors the restore pulse
    check("R6", "cacheDiscard", longint'(cacheDiscard), longint'(mRst));
    check(tag, "commitDone", longint'(commitDone), longint'(mDone));
    check(tag, "overflowFail", longint'(overflowFail), longint'(mOvf));
    // R10: restore bus packing and hold
    check(tag, "restoreRegs", longint'(restoreRegs), longint'(expRegs));
    check(tag, "restorePc", longint'(restorePc), longint'(mRstPc));
  endtask

  task automatic doRestore();
    for (int k = 0; k < NREG; k++) mRstReg[k] = mReg[k];
    mRstPc = mPc;
    mRst = 1;
    mDepth = 0;
    mValid = 0;
  endtask

  task automatic modelEdge();
    mRst = 0; mOvf = 0; mDone = 0;
    if (abortStb) begin
      if (mDepth > 0) doRestore();
    end else if (commitStb) begin
      if (mDepth == 1) begin mDepth = 0; mValid = 0; mDone = 1; end
      else if (mDepth > 1) mDepth--;
    end else if (beginStb) begin
      if (mDepth == 0) begin
        for (int k = 0; k < NREG; k++) mReg[k] = int'(snapRegs[k*RW +: RW]);
        mPc = int'(snapPc);
        mDepth = 1; mValid = 1; mId = (mId + 1) % (1 << IW);
      end else if (mDepth == MAXD) begin
        mOvf = 1;
        doRestore();
      end else mDepth++;
    end
  endtask

  task automatic step(input logic b, input logic c, input logic a, input string tag);
    beginStb = b; commitStb = c; abortStb = a;
    snapRegs = {$urandom(), $urandom()};
    snapPc = PW'($urandom());
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < NREG; k++) begin mReg[k] = 0; mRstReg[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    step(0, 0, 0, "R1");
    // R8: commit and abort while idle
    step(0, 1, 0, "R8");
    step(0, 0, 1, "R8");
    // R2, R3, R7: nest to the limit and overflow
    step(1, 0, 0, "R2");
    for (int i = 0; i < MAXD - 1; i++) step(1, 0, 0, "R3");
    step(1, 0, 0, "R7");
    step(0, 0, 0, "R10");
    step(0, 1, 0, "R8");
    // R4: nested commits
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R3");
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R4");
    // R5: abort from depth 2
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R3");
    step(0, 0, 1, "R5");
    step(0, 0, 0, "R10");
    // R9: ranking of simultaneous strobes
    step(1, 1, 1, "R9");
    step(1, 1, 0, "R9");
    step(1, 0, 0, "R2");
    step(1, 1, 0, "R9");
    step(1, 0, 0, "R2");
    step(1, 0, 1, "R9");
    step(1, 0, 0, "R2");
    step(1, 1, 1, "R9");
    // R2: identifier wrap
    for (int i = 0; i < 260; i++) begin
      step(1, 0, 0, "R2");
      step(0, 1, 0, "R4");
    end
    // R9: random mixed strobes
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      step(r < 4, r == 4 || r == 8, r == 5, "R9");
    end
    summary();
  end
endmodule